// File: doc/BRIEF.md
# Bus Master Access Control Unit

This unit sits beside a multi-master on-chip bus. It holds one privilege bit for each bus master and a bank of byte-wide control registers. Each control byte carries two 4-bit permission fields, one for each of two targets. The unit works out the user/supervisor attribute that each bus access really carries. A master whose privilege bit is clear is always treated as user mode. A master whose bit is set keeps the attribute it drives itself.

Software programs the unit through a register port. Every access on that port is tagged with a master number and a supervisor flag. Writes to the defined registers are taken only from trusted masters. A trusted master is one whose privilege bit is set and which drives the supervisor attribute. The core master 0 is trusted whenever it drives the supervisor attribute, whatever its privilege bit holds. Any other write to a defined register is refused with an error, and the register is left unchanged.

A separate check port takes a master, a supervisor flag, a read/write flag and a target number. One cycle later it reports three things: whether the access may be forwarded, an error pulse if the access is refused, and the effective attribute of the access.

Top module: `bmac_top`

## Requirements
- R1: After reset, the privilege register reads 0x03. Every control byte at offsets 0x24 to 0x33 reads 0xCC. Every other offset reads 0x00.
- R2: The privilege register is at offset 0x20. Bits 7..4 of this register always read 0, whatever value is written to them.
- R3: The effective attribute of an access is supervisor only when the privilege bit of its master is 1 and the access drives the supervisor attribute. In every other case the access is treated as user mode.
- R4: A write to a defined register (0x20, or 0x24 to 0x33) by master m with supervisor flag s is accepted only if s is 1 and either m is 0 or the privilege bit of m is 1. Any other such write raises reg_err in the cycle it is presented, and no register changes.
- R5: Master 0 in supervisor mode can always write the registers, even after its own privilege bit has been cleared.
- R6: Offsets outside 0x20 and 0x24 to 0x33 read 0x00 and never raise reg_err. A write to one of these offsets changes nothing, whichever master issues it.
- R7: reg_ready equals reg_valid in the same cycle. A read never raises reg_err.
- R8: Check targets 2k and 2k+1 use the control byte at offset 0x24+k. Target 2k uses bits 7..4 of that byte and target 2k+1 uses bits 3..0. The byte index k runs from 0 to 15, so offsets 0x30 to 0x33 hold targets 24 to 31. Within a 4-bit field, bit 3 allows supervisor reads, bit 2 allows supervisor writes, bit 1 allows user reads and bit 0 allows user writes. The field bit that applies is chosen by the effective attribute.
- R9: One cycle after a check request, exactly one of acc_fwd and acc_err is 1. acc_fwd is 1 when the field allows the access, and acc_err is 1 when it does not. One cycle after a cycle with no request, both are 0.
- R10: acc_eff_sup reports, one cycle after the request, the effective attribute of that request as defined in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte offset within the unit |
| reg_wdata | input | 8 | Write data |
| reg_master | input | 2 | Number of the requesting master |
| reg_super | input | 1 | Supervisor attribute driven by the requester |
| reg_ready | output | 1 | Access completes this cycle |
| reg_err | output | 1 | Write refused by the trust rule |
| reg_rdata | output | 8 | Read data |
| acc_valid | input | 1 | Check request |
| acc_write | input | 1 | Checked access is a write |
| acc_master | input | 2 | Master of the checked access |
| acc_super | input | 1 | Supervisor attribute of the checked access |
| acc_tgt | input | 5 | Target number of the checked access |
| acc_fwd | output | 1 | Registered: access allowed |
| acc_err | output | 1 | Registered: one-cycle refusal pulse |
| acc_eff_sup | output | 1 | Registered: effective attribute |

## Verification
Some properties are checked on every cycle. These are the upper privilege bits staying zero, a refused write leaving every register stable, reads and reserved offsets never raising an error, the supervisor core never being refused, and the check outputs being mutually exclusive with one outcome per request. Other behaviour can only be shown by the bench's sweeps. These cover the reset contents at all 64 offsets, the trust decision for every master, attribute and privilege pattern, and the mapping of targets to bytes and nibbles. They also cover the choice of field bit for every combination of target, master, attribute and direction.

// File: rtl/bmac_pkg.sv
// Package bmac_pkg
// Shared definitions for the bus master access control unit: the bit
// positions inside a 4-bit permission field and the permission decision.
// Assumes the field layout given in the brief (R8).
package bmac_pkg;
    localparam int FLD_SUP_RD = 3;
    localparam int FLD_SUP_WR = 2;
    localparam int FLD_USR_RD = 1;
    localparam int FLD_USR_WR = 0;

    // Decide whether a field grants an access of the given kind.
    function automatic logic field_allows(input logic [3:0] fld,
                                          input logic       sup,
                                          input logic       wr);
        logic res;
        if (sup) res = wr ? fld[FLD_SUP_WR] : fld[FLD_SUP_RD];
        else     res = wr ? fld[FLD_USR_WR] : fld[FLD_USR_RD];
        return res;
    endfunction
endpackage

// File: rtl/bmac_attr.sv
// Module bmac_attr
// Purely combinational. Selects one master and derives two things for the
// current access: its effective supervisor attribute and whether it counts
// as trusted for register writes. Master 0 is trusted whenever it drives
// supervisor. Assumes 2 <= N_MASTERS <= 8.
module bmac_attr #(
    parameter int N_MASTERS = 4,
    localparam int MID_W = $clog2(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] priv_i,
    input  logic [MID_W-1:0]     master_i,
    input  logic                 sup_i,
    output logic                 eff_sup_o,
    output logic                 trusted_o
);
    logic [N_MASTERS-1:0] sel_v;
    logic [N_MASTERS-1:0] eff_v;
    logic [N_MASTERS-1:0] tr_v;

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_mst
        assign sel_v[i] = (master_i == MID_W'(i));
        assign eff_v[i] = priv_i[i] & sup_i;
        if (i == 0) begin : g_core
            assign tr_v[i] = sup_i;
        end else begin : g_other
            assign tr_v[i] = priv_i[i] & sup_i;
        end
    end

    // Reduce the selected master's decode onto the outputs.
    always_comb begin
        eff_sup_o = |(sel_v & eff_v);
        trusted_o = |(sel_v & tr_v);
    end

    // Guard: neither result may claim supervisor for a user-mode access.
    always_comb begin
        if (eff_sup_o) begin
            // R3
            eff_needs_sup_chk: assert (sup_i);
        end
        if (trusted_o) begin
            // R4
            trust_needs_sup_chk: assert (sup_i);
        end
    end
endmodule

// File: rtl/bmac_regs.sv
// Module bmac_regs
// Register file: one privilege register and N_CTRL control bytes. Control
// byte k sits at PACR_BASE+k for k < N_PACR and at GACR_BASE+k-N_PACR
// otherwise. The access completes in the same cycle: read data and the
// error flag are combinational, and writes commit at the clock edge.
// A write to a defined offset is refused when trusted_i is low. Offsets
// that are not defined read zero and ignore writes.
module bmac_regs #(
    parameter int N_MASTERS = 4,
    parameter int ADDR_W    = 6,
    parameter int PRIV_OFS  = 'h20,
    parameter int PACR_BASE = 'h24,
    parameter int N_PACR    = 12,
    parameter int GACR_BASE = 'h30,
    parameter int N_GACR    = 4,
    parameter logic [7:0] PRIV_RST = 8'h03,
    parameter logic [3:0] FIELD_RST = 4'hC,
    localparam int N_CTRL = N_PACR + N_GACR
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic                  write_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [7:0]            wdata_i,
    input  logic                  trusted_i,
    output logic [7:0]            rdata_o,
    output logic                  err_o,
    output logic [N_MASTERS-1:0]  priv_o,
    output logic [N_CTRL*8-1:0]   ctrl_o
);
    localparam logic [7:0] PRIV_MASK = 8'((1 << N_MASTERS) - 1);

    logic [7:0]          priv_q;
    logic [N_CTRL*8-1:0] ctrl_q;
    logic                hit_priv;
    logic [N_CTRL-1:0]   hit_ctrl;
    logic                defined;
    logic                wr_ok;

    assign hit_priv = valid_i && (addr_i == ADDR_W'(PRIV_OFS));

    for (genvar k = 0; k < N_CTRL; k++) begin : g_dec
        localparam int BYTE_OFS = (k < N_PACR) ? (PACR_BASE + k)
                                               : (GACR_BASE + k - N_PACR);
        assign hit_ctrl[k] = valid_i && (addr_i == ADDR_W'(BYTE_OFS));
    end

    // Classify the access: defined target, accepted write, refused write.
    always_comb begin
        defined = hit_priv | (|hit_ctrl);
        wr_ok   = write_i & defined & trusted_i;
        err_o   = write_i & defined & ~trusted_i;
    end

    // Privilege register: reserved upper bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                 priv_q <= PRIV_RST & PRIV_MASK;
        else if (wr_ok && hit_priv) priv_q <= wdata_i & PRIV_MASK;
    end

    // Control bytes: each one is loaded only by an accepted write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= {(2*N_CTRL){FIELD_RST}};
        end else if (wr_ok) begin
            for (int k = 0; k < N_CTRL; k++) begin
                if (hit_ctrl[k]) ctrl_q[k*8 +: 8] <= wdata_i;
            end
        end
    end

    // Read multiplexer: offsets that are not defined return zero.
    always_comb begin
        rdata_o = '0;
        if (hit_priv) rdata_o = priv_q;
        for (int k = 0; k < N_CTRL; k++) begin
            if (hit_ctrl[k]) rdata_o = ctrl_q[k*8 +: 8];
        end
    end

    assign priv_o = priv_q[N_MASTERS-1:0];
    assign ctrl_o = ctrl_q;

    // R2
    priv_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_q & ~PRIV_MASK) == 8'h00);

    // R4
    refused_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && err_o) |=> ($stable(priv_q) && $stable(ctrl_q)));

    // R6
    reserved_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !defined) |-> (!err_o && rdata_o == 8'h00));

    // R7
    read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !write_i) |-> !err_o);
endmodule

// File: rtl/bmac_gate.sv
// Module bmac_gate
// Permission check for one access per cycle. It picks the control byte
// for the target (target>>1), then the nibble: the high nibble for an even
// target and the low nibble for an odd one. The field is tested against
// the effective attribute and direction. The result is registered, so the
// outputs show the outcome one cycle after the request. Targets at or
// above N_TGT are refused. Assumes N_TGT >= 4.
module bmac_gate #(
    parameter int N_CTRL = 16,
    localparam int N_TGT = 2 * N_CTRL,
    localparam int TGT_W = $clog2(N_TGT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic                write_i,
    input  logic [TGT_W-1:0]    tgt_i,
    input  logic                eff_sup_i,
    input  logic [N_CTRL*8-1:0] ctrl_i,
    output logic                fwd_o,
    output logic                err_o,
    output logic                eff_sup_o
);
    import bmac_pkg::*;

    logic [7:0] byte_sel;
    logic [3:0] fld;
    logic       in_rng;
    logic       allow;

    if (N_TGT < (1 << TGT_W)) begin : g_rng
        assign in_rng = (int'(tgt_i) < N_TGT);
    end else begin : g_full
        assign in_rng = 1'b1;
    end

    // Select the control byte and nibble for the requested target.
    always_comb begin
        byte_sel = '0;
        for (int k = 0; k < N_CTRL; k++) begin
            if (tgt_i[TGT_W-1:1] == (TGT_W-1)'(k)) byte_sel = ctrl_i[k*8 +: 8];
        end
        fld   = tgt_i[0] ? byte_sel[3:0] : byte_sel[7:4];
        allow = in_rng & field_allows(fld, eff_sup_i, write_i);
    end

    // Register the outcome: forward or refuse, plus the effective attribute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_o     <= 1'b0;
            err_o     <= 1'b0;
            eff_sup_o <= 1'b0;
        end else begin
            fwd_o     <= valid_i & allow;
            err_o     <= valid_i & ~allow;
            eff_sup_o <= valid_i & eff_sup_i;
        end
    end

    // R9
    fwd_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_o && err_o));

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (fwd_o || err_o));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!fwd_o && !err_o && !eff_sup_o));
endmodule

// File: rtl/bmac_top.sv
// Module bmac_top
// Bus master access control unit. It ties together the register file, one
// attribute/trust decoder for the register port, a second decoder for the
// check port, and the permission gate. The register port completes in the
// same cycle it is presented (ready follows valid). The check port answers
// one cycle after each request.
module bmac_top #(
    parameter int N_MASTERS = 4,
    parameter int ADDR_W    = 6,
    parameter int N_PACR    = 12,
    parameter int N_GACR    = 4,
    localparam int MID_W  = $clog2(N_MASTERS),
    localparam int N_CTRL = N_PACR + N_GACR,
    localparam int TGT_W  = $clog2(2 * N_CTRL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [MID_W-1:0]  reg_master,
    input  logic              reg_super,
    output logic              reg_ready,
    output logic              reg_err,
    output logic [7:0]        reg_rdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [MID_W-1:0]  acc_master,
    input  logic              acc_super,
    input  logic [TGT_W-1:0]  acc_tgt,
    output logic              acc_fwd,
    output logic              acc_err,
    output logic              acc_eff_sup
);
    logic [N_MASTERS-1:0]  priv;
    logic [N_CTRL*8-1:0]   ctrl;
    logic                  reg_trusted;
    logic                  reg_eff_unused;
    logic                  acc_eff;
    logic                  acc_tr_unused;

    assign reg_ready = reg_valid;

    bmac_attr #(.N_MASTERS(N_MASTERS)) u_attr_reg (
        .priv_i(priv), .master_i(reg_master), .sup_i(reg_super),
        .eff_sup_o(reg_eff_unused), .trusted_o(reg_trusted)
    );

    bmac_attr #(.N_MASTERS(N_MASTERS)) u_attr_acc (
        .priv_i(priv), .master_i(acc_master), .sup_i(acc_super),
        .eff_sup_o(acc_eff), .trusted_o(acc_tr_unused)
    );

    bmac_regs #(
        .N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W),
        .N_PACR(N_PACR), .N_GACR(N_GACR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .valid_i(reg_valid), .write_i(reg_write),
        .addr_i(reg_addr), .wdata_i(reg_wdata), .trusted_i(reg_trusted),
        .rdata_o(reg_rdata), .err_o(reg_err), .priv_o(priv), .ctrl_o(ctrl)
    );

    bmac_gate #(.N_CTRL(N_CTRL)) u_gate (
        .clk(clk), .rst_n(rst_n), .valid_i(acc_valid), .write_i(acc_write),
        .tgt_i(acc_tgt), .eff_sup_i(acc_eff), .ctrl_i(ctrl),
        .fwd_o(acc_fwd), .err_o(acc_err), .eff_sup_o(acc_eff_sup)
    );

    // R5
    core_sup_never_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_master == '0 && reg_super) |-> !reg_err);

    // R10
    eff_sup_needs_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (acc_eff_sup == ($past(acc_super) && $past(priv[acc_master]))));

    // R7
    ready_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ready == reg_valid);
endmodule

// File: tb/sim_bmac_top.sv
`timescale 1ns/1ps
module sim_bmac_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_valid = 1'b0, reg_write = 1'b0, reg_super = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] reg_master = '0;
    logic       reg_ready, reg_err;
    logic [7:0] reg_rdata;
    logic       acc_valid = 1'b0, acc_write = 1'b0, acc_super = 1'b0;
    logic [1:0] acc_master = '0;
    logic [4:0] acc_tgt = '0;
    logic       acc_fwd, acc_err, acc_eff_sup;

    int total = 0;
    int bad = 0;
    logic [7:0] model [64];

    always #2.5 clk = ~clk;

    bmac_top u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_master(reg_master), .reg_super(reg_super),
        .reg_ready(reg_ready), .reg_err(reg_err), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_master(acc_master),
        .acc_super(acc_super), .acc_tgt(acc_tgt),
        .acc_fwd(acc_fwd), .acc_err(acc_err), .acc_eff_sup(acc_eff_sup)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_defined(input int a);
        return (a == 'h20) || (a >= 'h24 && a <= 'h33);
    endfunction

    task automatic reg_op(input bit wr, input int a, input int d, input int m, input bit s,
                          output logic [7:0] rd, output logic er, output logic rdy);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_addr = 6'(a);
        reg_wdata = 8'(d); reg_master = 2'(m); reg_super = s;
        #1;
        rd = reg_rdata; er = reg_err; rdy = reg_ready;
        @(posedge clk);
        #1;
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic acc_op(input int m, input bit s, input bit w, input int t,
                          output logic f, output logic e, output logic es);
        @(negedge clk);
        acc_valid = 1'b1; acc_master = 2'(m); acc_super = s;
        acc_write = w; acc_tgt = 5'(t);
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        f = acc_fwd; e = acc_err; es = acc_eff_sup;
    endtask

    // Model of a write that follows R2, R4, R5 and R6.
    task automatic model_write(input int a, input int d, input int m, input bit s,
                               output bit exp_err);
        bit tr;
        tr = s && (m == 0 || model['h20][m]);
        exp_err = is_defined(a) && !tr;
        if (is_defined(a) && tr) model[a] = (a == 'h20) ? 8'(d & 'h0F) : 8'(d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic er, rdy, f, e, es;
        bit xe;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: outputs quiet after reset
        #1;
        check(!acc_fwd && !acc_err && !acc_eff_sup, "R9 reset outputs", {acc_fwd, acc_err}, 0);

        // R1, R6, R7: reset contents at every offset, read by an untrusted master
        for (int a = 0; a < 64; a++) begin
            model[a] = (a == 'h20) ? 8'h03 : (is_defined(a) ? 8'hCC : 8'h00);
            reg_op(1'b0, a, 0, 3, 1'b0, rd, er, rdy);
            check(rd == model[a], "R1 reset read", rd, model[a]);
            check(!er && rdy, "R7 read no err", {er, rdy}, 1);
        end

        // R2, R4, R5: every privilege pattern, then every master/attribute writing a control byte
        for (int p = 0; p < 16; p++) begin
            reg_op(1'b1, 'h20, p | 'hA0, 0, 1'b1, rd, er, rdy);
            model_write('h20, p | 'hA0, 0, 1'b1, xe);
            check(er == xe, "R5 core write", er, xe);
            reg_op(1'b0, 'h20, 0, 0, 1'b1, rd, er, rdy);
            check(rd == 8'(p), "R2 priv readback", rd, p);
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    int v;
                    int tg;
                    v  = (p * 16 + m * 4 + s * 2 + 1) & 'hFF;
                    tg = 'h24 + ((p + m) % 16);
                    reg_op(1'b1, tg, v, m, s[0], rd, er, rdy);
                    model_write(tg, v, m, s[0], xe);
                    check(er == xe, "R4 write err", er, xe);
                    reg_op(1'b0, tg, 0, 0, 1'b1, rd, er, rdy);
                    check(rd == model[tg], "R4 content", rd, model[tg]);
                end
            end
            // R4: untrusted master 3 in user mode tries to rewrite the privilege register
            reg_op(1'b1, 'h20, 'h0F, 3, 1'b0, rd, er, rdy);
            check(er == 1'b1, "R4 priv write refused", er, 1);
            reg_op(1'b0, 'h20, 0, 0, 1'b1, rd, er, rdy);
            check(rd == model['h20], "R4 priv unchanged", rd, model['h20]);
        end

        // R6: writes to undefined offsets by trusted and untrusted masters
        foreach (model[a]) begin
            if (!is_defined(a)) begin
                reg_op(1'b1, a, 'h5A, 3, 1'b0, rd, er, rdy);
                check(!er, "R6 reserved write no err", er, 0);
                reg_op(1'b1, a, 'hA5, 0, 1'b1, rd, er, rdy);
                check(!er, "R6 reserved write no err", er, 0);
                reg_op(1'b0, a, 0, 0, 1'b1, rd, er, rdy);
                check(rd == 8'h00, "R6 reserved reads zero", rd, 0);
            end
        end

        // R8, R9, R10: set the privilege pattern and control bytes, then sweep every check request
        reg_op(1'b1, 'h20, 'h05, 0, 1'b1, rd, er, rdy);
        model_write('h20, 'h05, 0, 1'b1, xe);
        for (int k = 0; k < 16; k++) begin
            reg_op(1'b1, 'h24 + k, (k * 37 + 5) & 'hFF, 0, 1'b1, rd, er, rdy);
            model_write('h24 + k, (k * 37 + 5) & 'hFF, 0, 1'b1, xe);
        end
        for (int t = 0; t < 32; t++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [7:0] b;
                        logic [3:0] fl;
                        bit ef, al;
                        b  = model['h24 + t / 2];
                        fl = (t % 2 == 1) ? b[3:0] : b[7:4];
                        ef = s[0] && model['h20][m];
                        al = ef ? (w[0] ? fl[2] : fl[3]) : (w[0] ? fl[0] : fl[1]);
                        acc_op(m, s[0], w[0], t, f, e, es);
                        check(f == al && e == !al, "R8 R9 permission", {f, e}, {al, !al});
                        check(es == ef, "R10 effective attr", es, ef);
                    end
                end
            end
        end

        // R9: an idle cycle leaves the outputs low and ends the error pulse
        @(negedge clk);
        @(posedge clk);
        #1;
        check(!acc_fwd && !acc_err, "R9 idle", {acc_fwd, acc_err}, 0);

        // R3: a master whose privilege bit is clear stays user even when it drives supervisor
        acc_op(1, 1'b1, 1'b0, 0, f, e, es);
        check(es == 1'b0, "R3 clear bit forces user", es, 0);
        acc_op(2, 1'b1, 1'b0, 0, f, e, es);
        check(es == 1'b1, "R3 set bit passes attr", es, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule